// File: doc/BRIEF.md
# Cascaded CAM Priority Flag Chain

This block holds the cascade logic for a vertical stack of content-addressable memory devices that together act as one deeper memory. Each device in the stack keeps its own result of the last compare (hit, multiple hit, hit confirmed by the secondary table) and its own full status. Each device also drives four active-low flags to the device below it. Across the stack these flags form four combinational chains: match, multiple match, full and match-valid. The top device has its match input tied inactive and its full input tied active. The flags leaving the bottom device summarise the whole stack.

The local results do not feed the chain directly. They are captured only when the active-low cycle strobe returns high. Compare results are captured at the end of a compare cycle. Full status is captured at the end of a write cycle. A cycle of any other kind, such as a control register write, can run while the chain is still settling and leaves every captured flag unchanged. From the settled chain each device works out two things. The first is whether it holds the top-priority match; only that device may drive the shared data and address buses during a read of the best match. The second is whether it is the first device with room, which is where the next write goes. Bus drive is given as one enable per device in place of tri-state pads.

Top module: `cam_cascade_stack`

## Requirements
- R1: While reset is low, and after it until the first captured cycle, every match, multiple-match, match-valid and full flag is high (inactive) and no device has bus drive. The write target is device 0.
- R2: `op_kind` is decoded as 0 = other cycle, 1 = compare, 2 = write, 3 = read best match. It is sampled at the clock edge where `strobe_n` is first seen high after having been low. On such an edge with a compare cycle, each device captures `loc_match`, `loc_multi` and `loc_match & loc_tmatch`. Captured results do not change while the strobe is low.
- R3: On a strobe rising edge with a write cycle, each device captures `loc_full`. The captured compare results are left unchanged.
- R4: A rising edge with the other-cycle or read code, or any change of the local inputs with no rising edge, changes no captured flag. All chain outputs stay as they were.
- R5: `mf_n[i]` is low exactly when at least one device among 0..i holds a captured hit.
- R6: `mm_n[i]` is low exactly when devices 0..i together hold two or more captured hits, or at least one of them holds a captured multiple hit.
- R7: `ff_n[i]` is low exactly when every device among 0..i holds a captured full status.
- R8: `mv_n[i]` is low exactly when at least one device among 0..i holds a captured hit that its secondary table confirmed.
- R9: `drive_en[i]` is high only while `strobe_n` is low and `op_kind` is 3, and only for the lowest-numbered device with a captured hit. At most one bit is ever high.
- R10: `wr_sel` has exactly one bit high, at the lowest-numbered device whose captured full status is clear. It is all zero when every device is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| strobe_n | input | 1 | Cycle strobe, active low; results are captured on its return high |
| op_kind | input | 2 | Cycle kind: 0 other, 1 compare, 2 write, 3 read best match |
| loc_match | input | NUM_DEV | Local compare hit, one bit per device |
| loc_multi | input | NUM_DEV | Local multiple hit, one bit per device |
| loc_tmatch | input | NUM_DEV | Secondary table hit, one bit per device |
| loc_full | input | NUM_DEV | Local array full, one bit per device |
| mf_n | output | NUM_DEV | Match flag leaving each device, active low |
| mm_n | output | NUM_DEV | Multiple-match flag leaving each device, active low |
| ff_n | output | NUM_DEV | Full flag leaving each device, active low |
| mv_n | output | NUM_DEV | Match-valid flag leaving each device, active low |
| drive_en | output | NUM_DEV | Bus drive enable of the top-priority matching device |
| wr_sel | output | NUM_DEV | Target device of the next write |

## Verification
The bench builds the stack with five devices, one more than the default. This gives chains long enough to hold a hit that sits below two other hits, a multiple hit that appears only at the third link, and a full chain that breaks at an interior device. Directed cycles cover the empty stack, a completely full stack and a hit only at the bottom device. A long run of random cycles with random strobe low times then mixes every cycle kind and input pattern against a behavioural model that recomputes each flag by scanning the devices.

// File: rtl/cas_pkg.sv
// Shared types for the cascaded CAM flag chain.
// Assumes op codes are stable while the strobe is low.
package cas_pkg;

    typedef enum logic [1:0] {
        OP_OTHER = 2'd0,
        OP_CMP   = 2'd1,
        OP_WR    = 2'd2,
        OP_RD    = 2'd3
    } cas_op_e;

endpackage

// File: rtl/cas_edge_detect.sv
// Detects the return of the active-low cycle strobe to high.
// Assumes strobe_n is synchronous to clk. The pulse is one cycle wide and
// coincides with the first clock edge that sees the strobe high again.
module cas_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n,
    output logic rise
);

    logic strobe_q;

    // Remember the strobe level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b1;
        else        strobe_q <= strobe_n;
    end

    // Rising edge: low last cycle, high now.
    always_comb rise = strobe_n & ~strobe_q;

    // R2: a capture pulse never lasts two cycles.
    p_single_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/cas_flag_store.sv
// Holds the captured compare results and full status of every device.
// Compare results load at the end of a compare cycle and full status loads
// at the end of a write cycle. Any other cycle leaves all of it untouched.
module cas_flag_store #(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rise,
    input  logic [1:0]         op_kind,
    input  logic [NUM_DEV-1:0] loc_match,
    input  logic [NUM_DEV-1:0] loc_multi,
    input  logic [NUM_DEV-1:0] loc_tmatch,
    input  logic [NUM_DEV-1:0] loc_full,
    output logic [NUM_DEV-1:0] hit_q,
    output logic [NUM_DEV-1:0] multi_q,
    output logic [NUM_DEV-1:0] valid_q,
    output logic [NUM_DEV-1:0] full_q
);
    import cas_pkg::*;

    logic load_cmp;
    logic load_wr;

    // Decode which group of flags this edge loads.
    always_comb begin
        load_cmp = rise && (cas_op_e'(op_kind) == OP_CMP);
        load_wr  = rise && (cas_op_e'(op_kind) == OP_WR);
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
        // Compare results of device d, loaded at the end of a compare cycle.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hit_q[d]   <= 1'b0;
                multi_q[d] <= 1'b0;
                valid_q[d] <= 1'b0;
            end else if (load_cmp) begin
                hit_q[d]   <= loc_match[d];
                multi_q[d] <= loc_multi[d];
                valid_q[d] <= loc_match[d] & loc_tmatch[d];
            end
        end

        // Full status of device d, loaded at the end of a write cycle.
        always_ff @(posedge clk) begin
            if (!rst_n)       full_q[d] <= 1'b0;
            else if (load_wr) full_q[d] <= loc_full[d];
        end
    end

    // R4: without a capture pulse nothing moves.
    p_hold_no_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rise |=> $stable({hit_q, multi_q, valid_q, full_q}));

    // R3: a write cycle keeps the compare results.
    p_wr_keeps_hits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> $stable({hit_q, multi_q, valid_q}));

    // R2: a compare cycle keeps the full status.
    p_cmp_keeps_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_cmp |=> $stable(full_q));

endmodule

// File: rtl/cas_chain_cell.sv
// One link of the cascade, purely combinational.
// It takes the active-low flags from the device above and merges in the
// captured state of this device. It reports whether this device holds the
// top-priority hit and whether it is the first device with room.
module cas_chain_cell (
    input  logic mi_n,
    input  logic mmi_n,
    input  logic fi_n,
    input  logic mvi_n,
    input  logic hit,
    input  logic multi,
    input  logic valid,
    input  logic full,
    output logic mf_n,
    output logic mm_n,
    output logic ff_n,
    output logic mv_n,
    output logic responder,
    output logic wr_target
);

    logic up_hit;

    // Merge the upstream flags with this device's state.
    always_comb begin
        up_hit    = ~mi_n;
        mf_n      = ~(up_hit | hit);
        mm_n      = ~(~mmi_n | multi | (hit & up_hit));
        ff_n      = ~(~fi_n & full);
        mv_n      = ~(~mvi_n | valid);
        responder = mi_n & hit;
        wr_target = ~fi_n & ~full;
    end

endmodule

// File: rtl/cam_cascade_stack.sv
// A vertical stack of NUM_DEV CAM devices joined by their cascade flags.
// Device 0 has the highest priority. Its match input is tied inactive and
// its full input is tied active. Bus drive is shown as one enable per
// device; the pads are outside this block.
module cam_cascade_stack #(
    parameter int NUM_DEV = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe_n,
    input  logic [1:0]         op_kind,
    input  logic [NUM_DEV-1:0] loc_match,
    input  logic [NUM_DEV-1:0] loc_multi,
    input  logic [NUM_DEV-1:0] loc_tmatch,
    input  logic [NUM_DEV-1:0] loc_full,
    output logic [NUM_DEV-1:0] mf_n,
    output logic [NUM_DEV-1:0] mm_n,
    output logic [NUM_DEV-1:0] ff_n,
    output logic [NUM_DEV-1:0] mv_n,
    output logic [NUM_DEV-1:0] drive_en,
    output logic [NUM_DEV-1:0] wr_sel
);
    import cas_pkg::*;

    localparam int LAST = NUM_DEV - 1;

    logic               rise;
    logic               rd_active;
    logic [NUM_DEV-1:0] hit_q, multi_q, valid_q, full_q;
    logic [NUM_DEV-1:0] responder;
    logic [NUM_DEV:0]   mi_c, mm_c, fi_c, mv_c;

    cas_edge_detect u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (strobe_n),
        .rise     (rise)
    );

    cas_flag_store #(.NUM_DEV(NUM_DEV)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .op_kind    (op_kind),
        .loc_match  (loc_match),
        .loc_multi  (loc_multi),
        .loc_tmatch (loc_tmatch),
        .loc_full   (loc_full),
        .hit_q      (hit_q),
        .multi_q    (multi_q),
        .valid_q    (valid_q),
        .full_q     (full_q)
    );

    // Tie off the inputs of the top device.
    always_comb begin
        mi_c[0] = 1'b1;
        mm_c[0] = 1'b1;
        mv_c[0] = 1'b1;
        fi_c[0] = 1'b0;
    end

    for (genvar d = 0; d < NUM_DEV; d++) begin : g_link
        cas_chain_cell u_cell (
            .mi_n      (mi_c[d]),
            .mmi_n     (mm_c[d]),
            .fi_n      (fi_c[d]),
            .mvi_n     (mv_c[d]),
            .hit       (hit_q[d]),
            .multi     (multi_q[d]),
            .valid     (valid_q[d]),
            .full      (full_q[d]),
            .mf_n      (mi_c[d+1]),
            .mm_n      (mm_c[d+1]),
            .ff_n      (fi_c[d+1]),
            .mv_n      (mv_c[d+1]),
            .responder (responder[d]),
            .wr_target (wr_sel[d])
        );
    end

    // Bring the chain out and gate bus drive with an active read cycle.
    always_comb begin
        mf_n      = mi_c[NUM_DEV:1];
        mm_n      = mm_c[NUM_DEV:1];
        ff_n      = fi_c[NUM_DEV:1];
        mv_n      = mv_c[NUM_DEV:1];
        rd_active = ~strobe_n && (cas_op_e'(op_kind) == OP_RD);
        drive_en  = rd_active ? responder : '0;
    end

    // R9: at most one device drives the shared buses.
    p_one_driver_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drive_en));

    // R10: at most one device is the write target.
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel));

    // R10: a full stack offers no write target.
    p_full_no_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ff_n[LAST] |-> (wr_sel == '0));

    for (genvar d = 1; d < NUM_DEV; d++) begin : g_chk
        // R9: a driver has no matching device above it.
        p_driver_on_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
            drive_en[d] |-> mf_n[d-1]);

        // R5: a match seen above is passed on downward.
        p_match_passes_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !mf_n[d-1] |-> !mf_n[d]);

        // R7: the full chain can only break going downward.
        p_full_breaks_r7: assert property (@(posedge clk) disable iff (!rst_n)
            mf_n[d-1] && ff_n[d-1] |-> ff_n[d]);
    end

endmodule

// File: tb/cam_cascade_stack_tb.sv
// Bench for the cascaded flag chain: a behavioural model that scans the
// devices is compared with the outputs on every clock.
module cam_cascade_stack_tb_top;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         strobe_n = 1'b1;
    logic [1:0]   op_kind = 2'd0;
    logic [N-1:0] loc_match = '0, loc_multi = '0, loc_tmatch = '0, loc_full = '0;
    logic [N-1:0] mf_n, mm_n, ff_n, mv_n, drive_en, wr_sel;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Model state.
    bit [N-1:0] m_hit, m_multi, m_valid, m_full;
    bit         m_sq;

    cam_cascade_stack #(.NUM_DEV(N)) dut_i (
        .clk, .rst_n, .strobe_n, .op_kind,
        .loc_match, .loc_multi, .loc_tmatch, .loc_full,
        .mf_n, .mm_n, .ff_n, .mv_n, .drive_en, .wr_sel
    );

    always #4 clk = ~clk;

    // Behavioural model of the capture rules.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hit = '0; m_multi = '0; m_valid = '0; m_full = '0; m_sq = 1'b1;
        end else begin
            if (!m_sq && strobe_n) begin
                if (op_kind == 2'd1) begin
                    m_hit = loc_match; m_multi = loc_multi;
                    m_valid = loc_match & loc_tmatch;
                end else if (op_kind == 2'd2) begin
                    m_full = loc_full;
                end
            end
            m_sq = strobe_n;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Compare every output with values derived by scanning the model.
    task automatic compare_all();
        logic [N-1:0] e_mf, e_mm, e_ff, e_mv, e_de, e_ws;
        int nhit = 0;
        bit anym = 0, anyv = 0, allf = 1, found = 0, wfound = 0;
        for (int i = 0; i < N; i++) begin
            nhit += m_hit[i];
            anym |= m_multi[i];
            anyv |= m_valid[i];
            allf &= m_full[i];
            e_mf[i] = !(nhit > 0);
            e_mm[i] = !(nhit >= 2 || anym);
            e_ff[i] = !allf;
            e_mv[i] = !anyv;
            e_de[i] = 0;
            e_ws[i] = 0;
            if (m_hit[i] && !found) begin
                found = 1;
                e_de[i] = (!strobe_n && op_kind == 2'd3);
            end
            if (!m_full[i] && !wfound) begin
                wfound = 1;
                e_ws[i] = 1;
            end
        end
        check("R5", "mf_n", mf_n, e_mf);
        check("R6", "mm_n", mm_n, e_mm);
        check("R7", "ff_n", ff_n, e_ff);
        check("R8", "mv_n", mv_n, e_mv);
        check("R9", "drive_en", drive_en, e_de);
        check("R10", "wr_sel", wr_sel, e_ws);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        compare_all();
    endtask

    // One strobed cycle: strobe low for 'low' clocks, then high for one.
    task automatic run_cycle(input logic [1:0] op, input logic [N-1:0] hm,
                             input logic [N-1:0] mu, input logic [N-1:0] tm,
                             input logic [N-1:0] fu, input int low);
        op_kind = op; loc_match = hm; loc_multi = mu; loc_tmatch = tm; loc_full = fu;
        strobe_n = 1'b0;
        for (int k = 0; k < low; k++) step();
        strobe_n = 1'b1;
        step();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [4*N-1:0] snap;
        repeat (3) step();
        // R1: flags inactive and device 0 is the write target during reset.
        check("R1", "flags in reset", mf_n & mm_n & ff_n & mv_n, '1);
        check("R1", "wr_sel in reset", wr_sel, 5'b00001);
        rst_n = 1'b1;
        step();
        check("R1", "drive_en after reset", drive_en, '0);

        // R2: compare with hits at 1 and 3; flags held while strobe low.
        op_kind = 2'd1; loc_match = 5'b01010; loc_tmatch = 5'b01000;
        strobe_n = 1'b0;
        step(); step();
        check("R2", "mf_n held while strobe low", mf_n, '1);
        strobe_n = 1'b1;
        step();
        check("R2", "mf_n after compare", mf_n, 5'b00001);
        check("R6", "two hits give multi", mm_n, 5'b00111);

        // R9: read cycle drives only device 1; R4: local inputs ignored.
        run_cycle(2'd3, 5'b11111, 5'b11111, 5'b11111, 5'b11111, 2);
        check("R9", "drive_en idle after read", drive_en, '0);

        // R4: other cycle with changed inputs leaves all flags.
        snap = {mf_n, mm_n, ff_n, mv_n};
        run_cycle(2'd0, 5'b10101, 5'b00100, 5'b11111, 5'b11111, 3);
        check("R4", "flags after other cycle", 5'(snap == {mf_n, mm_n, ff_n, mv_n}), 5'd1);

        // R3: write full status for devices 0 and 1; hits kept.
        run_cycle(2'd2, 5'b00000, 5'b00000, 5'b00000, 5'b00011, 1);
        check("R3", "wr_sel after write", wr_sel, 5'b00100);
        check("R3", "mf_n kept by write", mf_n, 5'b00001);

        // R10: full stack offers no target.
        run_cycle(2'd2, 5'b00000, 5'b00000, 5'b00000, 5'b11111, 1);
        check("R10", "wr_sel full stack", wr_sel, '0);
        check("R7", "ff_n full stack", ff_n, 5'b00000);

        // R5/R8: single hit at the bottom device only, confirmed by the table.
        run_cycle(2'd1, 5'b10000, 5'b00000, 5'b10000, 5'b00000, 1);
        check("R8", "mv_n bottom hit", mv_n, 5'b01111);
        strobe_n = 1'b0; op_kind = 2'd3;
        step();
        check("R9", "bottom device drives", drive_en, 5'b10000);
        strobe_n = 1'b1; op_kind = 2'd0;
        step();

        // R6: local multiple hit at device 2 alone.
        run_cycle(2'd1, 5'b00100, 5'b00100, 5'b00000, 5'b00000, 1);
        check("R6", "local multi", mm_n, 5'b00011);

        // Random cycles.
        for (int r = 0; r < 400; r++)
            run_cycle(2'($urandom_range(0, 3)), N'($urandom), N'($urandom),
                      N'($urandom), N'($urandom), $urandom_range(1, 3));

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule